// File: doc/BRIEF.md
# Hardware Function Call Proxy

This block lets local hardware invoke a function that is implemented somewhere else in the system, either in software or in another hardware unit. The call uses a push-only protocol with four channels. A local request port supplies a target endpoint base address, an argument count and a packed set of argument words, together with a one-cycle start strobe. An AXI4-Lite write master first pushes each argument into the callee's parameter slots. It then writes the proxy's own return-endpoint identifier into the callee's question register, and that write starts the callee.

The proxy never polls the callee. Its return endpoint is a small AXI4-Lite write-only slave region holding a result word and an answer word, and the callee pushes writes into them. When a nonzero answer arrives, the block raises a one-cycle completion strobe and presents the stored result. An argument word is carried as an opaque value, so it can hold a plain number or the address of another call endpoint that is used as a callback.

Top module: `hcall_proxy`

## Requirements
- R1: After reset, `call_busy`, `call_done`, `m_awvalid`, `m_wvalid` and `s_bvalid` are all low.
- R2: `req_start` is taken only while `call_busy` is low. A strobe seen while a call is outstanding produces no bus writes and does not alter the call in progress.
- R3: For an accepted call with argument count N, argument k is written before argument k+1. Argument k is bits [k*32 +: 32] of `req_args` and goes to address `req_target + 4*(k+1)`. A count above `MAX_ARGS` is treated as `MAX_ARGS`.
- R4: The last write of every call goes to address `req_target` (offset 0) and carries the value `RET_EP_ID`.
- R5: A call with a count of zero produces exactly one master write, the question write of R4.
- R6: The master has at most one write outstanding. A new address/data pair is not presented until the previous write response has been taken, and `m_awaddr`/`m_wdata` stay stable while valid is waiting for ready.
- R7: `call_busy` is high from the cycle after an accepted start until the cycle after the answer write is accepted. In that cycle it falls, together with the rise of `call_done`.
- R8: A slave write to offset 0x0 during an outstanding call stores the result word. A slave write of a nonzero value to offset 0x4 produces `call_done` high for exactly one cycle, with `call_result` equal to the stored result.
- R9: A zero value written to offset 0x4 does not complete the call.
- R10: Slave writes that arrive while no call is outstanding are acknowledged but change nothing. The stored result keeps its value and no completion occurs.
- R11: Every slave write receives exactly one write response with code OKAY (`2'b00`), and `s_bvalid` is held until `s_bready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle call request |
| req_target | input | ADDR_W | Callee endpoint base address |
| req_argc | input | ARGC_W | Number of argument words |
| req_args | input | MAX_ARGS*DATA_W | Packed argument words, argument 0 in the low word |
| call_busy | output | 1 | Call in progress |
| call_done | output | 1 | One-cycle completion strobe |
| call_result | output | DATA_W | Stored result word |
| m_awvalid | output | 1 | Master write address valid |
| m_awready | input | 1 | Master write address ready |
| m_awaddr | output | ADDR_W | Master write address |
| m_wvalid | output | 1 | Master write data valid |
| m_wready | input | 1 | Master write data ready |
| m_wdata | output | DATA_W | Master write data |
| m_wstrb | output | DATA_W/8 | Master byte strobes, all set |
| m_bvalid | input | 1 | Master write response valid |
| m_bready | output | 1 | Master write response ready |
| s_awvalid | input | 1 | Return endpoint write address valid |
| s_awready | output | 1 | Return endpoint write address ready |
| s_awaddr | input | S_ADDR_W | Return endpoint offset |
| s_wvalid | input | 1 | Return endpoint write data valid |
| s_wready | output | 1 | Return endpoint write data ready |
| s_wdata | input | DATA_W | Return endpoint write data |
| s_bvalid | output | 1 | Return endpoint response valid |
| s_bready | input | 1 | Return endpoint response ready |
| s_bresp | output | 2 | Return endpoint response code |

## Verification
The assertions assume that the remote slave on the master port follows AXI4-Lite rules: it answers each write with one response and never returns a response before accepting both the address and the data. They also assume that writers on the return endpoint hold address and data valid until ready. The bench's callee model only raises both readies together, after a random delay, and always answers afterwards. The bench's writer holds valid until it sees ready, and it sends the answer only after the question write has been logged. For this reason, an answer arriving before the question write response is never exercised.

// File: rtl/hcall_pkg.sv
// Package: shared types and constants for the hardware call proxy.
// Assumes full-word (32-bit aligned) access on the return endpoint.
package hcall_pkg;

    // Phases of one outgoing call
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARGS  = 2'd1,
        PH_QUEST = 2'd2,
        PH_WAIT  = 2'd3
    } call_phase_t;

    // Byte offsets of the return endpoint registers
    localparam int unsigned RET_OFF_DATA   = 0;
    localparam int unsigned RET_OFF_ANSWER = 4;

    // AXI response code for success
    localparam logic [1:0] AXI_RESP_OKAY = 2'b00;

endpackage

// File: rtl/hcall_wr_engine.sv
// Module: single-beat AXI4-Lite write engine.
// Takes one command (address, data) while idle, drives AW and W together,
// retires each channel on its own handshake, then waits for B.
// Assumes the remote slave returns exactly one B per write.
module hcall_wr_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_done,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    input  logic              m_bvalid,
    output logic              m_bready
);
    logic pend_q;

    assign cmd_ready = !pend_q;
    assign m_bready  = pend_q && !m_awvalid && !m_wvalid;
    assign cmd_done  = m_bvalid && m_bready;
    assign m_wstrb   = '1;

    // Launch a write on command, retire AW/W on handshake, end on B
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            m_awvalid <= 1'b0;
            m_wvalid  <= 1'b0;
            m_awaddr  <= '0;
            m_wdata   <= '0;
        end else if (cmd_valid && !pend_q) begin
            pend_q    <= 1'b1;
            m_awvalid <= 1'b1;
            m_wvalid  <= 1'b1;
            m_awaddr  <= cmd_addr;
            m_wdata   <= cmd_data;
        end else begin
            if (m_awvalid && m_awready) m_awvalid <= 1'b0;
            if (m_wvalid && m_wready)   m_wvalid  <= 1'b0;
            if (cmd_done)               pend_q    <= 1'b0;
        end
    end

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R6
    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata)); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> !$past(pend_q)); // R6

endmodule

// File: rtl/hcall_ret_slave.sv
// Module: return endpoint, a write-only AXI4-Lite slave with a result word
// and an answer word. Writes are taken only when AW and W are both valid.
// While not armed, writes are acknowledged and dropped.
// Assumes writers hold valid until ready; byte strobes are not used.
module hcall_ret_slave #(
    parameter int S_ADDR_W = 4,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                armed,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [S_ADDR_W-1:0] s_awaddr,
    input  logic                s_wvalid,
    output logic                s_wready,
    input  logic [DATA_W-1:0]   s_wdata,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [1:0]          s_bresp,
    output logic [DATA_W-1:0]   ret_value,
    output logic                a_evt
);
    import hcall_pkg::*;

    localparam logic [S_ADDR_W-1:0] OFF_D = S_ADDR_W'(RET_OFF_DATA);
    localparam logic [S_ADDR_W-1:0] OFF_A = S_ADDR_W'(RET_OFF_ANSWER);

    logic take;

    assign take      = s_awvalid && s_wvalid && !s_bvalid;
    assign s_awready = take;
    assign s_wready  = take;
    assign s_bresp   = AXI_RESP_OKAY;
    assign a_evt     = take && armed && (s_awaddr == OFF_A) && (s_wdata != '0);

    // Store the result word when a call is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n)
            ret_value <= '0;
        else if (take && armed && (s_awaddr == OFF_D))
            ret_value <= s_wdata;
    end

    // Raise one response per accepted write, drop it on ready
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_bvalid <= 1'b0;
        else if (take)
            s_bvalid <= 1'b1;
        else if (s_bready)
            s_bvalid <= 1'b0;
    end

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid); // R11
    AST_IDLE_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(ret_value)); // R10

endmodule

// File: rtl/hcall_sequencer.sv
// Module: call sequencer. Latches a request while idle, issues the argument
// writes in order, then the question write carrying the return endpoint id,
// then waits for a nonzero answer and emits a one-cycle done strobe.
// Assumes one command at a time is accepted by the write engine.
module hcall_sequencer #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_ARGS  = 4,
    parameter int ARGC_W    = 3,
    parameter logic [ADDR_W-1:0] RET_EP_ID = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_start,
    input  logic [ADDR_W-1:0]          req_target,
    input  logic [ARGC_W-1:0]          req_argc,
    input  logic [MAX_ARGS*DATA_W-1:0] req_args,
    output logic                       busy,
    output logic                       done,
    output logic                       armed,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [ADDR_W-1:0]          cmd_addr,
    output logic [DATA_W-1:0]          cmd_data,
    input  logic                       cmd_done,
    input  logic                       a_evt
);
    import hcall_pkg::*;

    localparam int SLOT_SHIFT = $clog2(DATA_W/8);

    call_phase_t                phase_q;
    logic [ADDR_W-1:0]          tgt_q;
    logic [ARGC_W-1:0]          argc_q;
    logic [ARGC_W-1:0]          sent_q;
    logic [MAX_ARGS*DATA_W-1:0] args_q;
    logic                       issued_q;
    logic                       a_seen_q;
    logic [ARGC_W-1:0]          argc_in;
    logic [ADDR_W-1:0]          slot_off;

    // Clamp the requested count to the slot count
    always_comb begin
        argc_in = (req_argc > ARGC_W'(MAX_ARGS)) ? ARGC_W'(MAX_ARGS) : req_argc;
    end

    // Byte offset of the next parameter slot
    always_comb begin
        slot_off = (ADDR_W'(sent_q) + ADDR_W'(1)) << SLOT_SHIFT;
    end

    assign busy      = (phase_q != PH_IDLE);
    assign armed     = (phase_q == PH_QUEST) || (phase_q == PH_WAIT);
    assign cmd_valid = ((phase_q == PH_ARGS) || (phase_q == PH_QUEST)) && !issued_q;
    assign cmd_addr  = (phase_q == PH_QUEST) ? tgt_q : (tgt_q + slot_off);
    assign cmd_data  = (phase_q == PH_QUEST) ? RET_EP_ID : args_q[DATA_W-1:0];

    // Step through the call phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            tgt_q    <= '0;
            argc_q   <= '0;
            sent_q   <= '0;
            args_q   <= '0;
            issued_q <= 1'b0;
            a_seen_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cmd_valid && cmd_ready) issued_q <= 1'b1;
            case (phase_q)
                PH_IDLE: begin
                    if (req_start) begin
                        tgt_q    <= req_target;
                        argc_q   <= argc_in;
                        args_q   <= req_args;
                        sent_q   <= '0;
                        issued_q <= 1'b0;
                        a_seen_q <= 1'b0;
                        phase_q  <= (argc_in == '0) ? PH_QUEST : PH_ARGS;
                    end
                end
                PH_ARGS: begin
                    if (cmd_done) begin
                        issued_q <= 1'b0;
                        sent_q   <= sent_q + ARGC_W'(1);
                        args_q   <= args_q >> DATA_W;
                        if ((sent_q + ARGC_W'(1)) == argc_q) phase_q <= PH_QUEST;
                    end
                end
                PH_QUEST: begin
                    if (a_evt) a_seen_q <= 1'b1;
                    if (cmd_done) begin
                        issued_q <= 1'b0;
                        if (a_seen_q || a_evt) begin
                            done    <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_WAIT;
                        end
                    end
                end
                PH_WAIT: begin
                    if (a_evt) begin
                        done    <= 1'b1;
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_ENDS_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy)); // R7
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_start |=> $stable(tgt_q) && $stable(argc_q)); // R2

endmodule

// File: rtl/hcall_proxy.sv
// Module: hardware function call proxy (top). Wires the sequencer, the
// write engine toward the callee and the return endpoint slave.
// Assumes the return endpoint region is mapped at RET_EP_ID by the system.
module hcall_proxy #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int MAX_ARGS = 4,
    parameter int S_ADDR_W = 4,
    parameter logic [ADDR_W-1:0] RET_EP_ID = 32'h4000_0000,
    localparam int ARGC_W  = $clog2(MAX_ARGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_start,
    input  logic [ADDR_W-1:0]          req_target,
    input  logic [ARGC_W-1:0]          req_argc,
    input  logic [MAX_ARGS*DATA_W-1:0] req_args,
    output logic                       call_busy,
    output logic                       call_done,
    output logic [DATA_W-1:0]          call_result,
    output logic                       m_awvalid,
    input  logic                       m_awready,
    output logic [ADDR_W-1:0]          m_awaddr,
    output logic                       m_wvalid,
    input  logic                       m_wready,
    output logic [DATA_W-1:0]          m_wdata,
    output logic [DATA_W/8-1:0]        m_wstrb,
    input  logic                       m_bvalid,
    output logic                       m_bready,
    input  logic                       s_awvalid,
    output logic                       s_awready,
    input  logic [S_ADDR_W-1:0]        s_awaddr,
    input  logic                       s_wvalid,
    output logic                       s_wready,
    input  logic [DATA_W-1:0]          s_wdata,
    output logic                       s_bvalid,
    input  logic                       s_bready,
    output logic [1:0]                 s_bresp
);
    logic              armed;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_done;
    logic              a_evt;

    hcall_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ARGS(MAX_ARGS),
        .ARGC_W(ARGC_W), .RET_EP_ID(RET_EP_ID)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .req_start(req_start), .req_target(req_target),
        .req_argc(req_argc), .req_args(req_args),
        .busy(call_busy), .done(call_done), .armed(armed),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_done(cmd_done), .a_evt(a_evt)
    );

    hcall_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_done(cmd_done),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    hcall_ret_slave #(.S_ADDR_W(S_ADDR_W), .DATA_W(DATA_W)) i_ret (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .ret_value(call_result), .a_evt(a_evt)
    );

endmodule

// File: tb/test_hcall_proxy.sv
module test_hcall_proxy;
    localparam int AW = 32, DW = 32, NA = 4, SAW = 4, CW = 3;
    localparam logic [31:0] RET = 32'h4000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_start = 1'b0;
    logic [AW-1:0] req_target = '0;
    logic [CW-1:0] req_argc = '0;
    logic [NA*DW-1:0] req_args = '0;
    logic call_busy, call_done;
    logic [DW-1:0] call_result;
    logic m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
    logic [AW-1:0] m_awaddr;
    logic [DW-1:0] m_wdata;
    logic [3:0] m_wstrb;
    logic s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b1;
    logic [SAW-1:0] s_awaddr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic s_awready, s_wready, s_bvalid;
    logic [1:0] s_bresp;

    int n_vec = 0, n_bad = 0;
    int log_cnt = 0;
    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];
    int done_cnt = 0;
    logic [31:0] done_val = '0;
    logic [31:0] exp_d = '0;

    always #5 clk = ~clk;

    hcall_proxy #(.RET_EP_ID(RET)) i_hcall_proxy (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_target(req_target),
        .req_argc(req_argc), .req_args(req_args), .call_busy(call_busy),
        .call_done(call_done), .call_result(call_result),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int eff_argc(input int n);
        return (n > NA) ? NA : n;
    endfunction

    function automatic logic [31:0] slot_addr(input logic [31:0] base, input int k);
        return base + 32'(4 * (k + 1));
    endfunction

    // Completion monitor: counts cycles with done high
    always @(negedge clk) begin
        if (call_done) begin
            done_cnt++;
            done_val = call_result;
        end
    end

    // Callee model on the master port: random ready delay, then one response
    initial begin
        m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && m_awvalid && m_wvalid) begin
                logic [31:0] a0, d0;
                a0 = m_awaddr; d0 = m_wdata;
                repeat ($urandom % 3) @(negedge clk);
                chk("R6 addr/data held while waiting", {m_awaddr, m_wdata}, {a0, d0});
                m_awready = 1'b1; m_wready = 1'b1;
                log_addr[log_cnt[7:0]] = m_awaddr;
                log_data[log_cnt[7:0]] = m_wdata;
                log_cnt++;
                @(negedge clk);
                m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b1;
                while (!m_bready) @(negedge clk);
                @(negedge clk);
                m_bvalid = 1'b0;
            end
        end
    end

    // One write into the return endpoint; checks its response
    task automatic ret_write(input logic [SAW-1:0] off, input logic [31:0] val);
        @(negedge clk);
        s_awvalid = 1'b1; s_wvalid = 1'b1; s_awaddr = off; s_wdata = val;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        chk("R11 response valid and OKAY", {s_bvalid, s_bresp}, {1'b1, 2'b00});
        @(negedge clk);
        chk("R11 single response", s_bvalid, 1'b0);
    endtask

    task automatic do_call(input logic [31:0] tgt, input int argc,
                           input logic [NA*DW-1:0] args, input logic [31:0] dval,
                           input bit send_d, input bit zero_a, input bit poke);
        int base, n, dc0, waitc;
        base = log_cnt; dc0 = done_cnt;
        n = eff_argc(argc) + 1;
        @(negedge clk);
        req_start = 1'b1; req_target = tgt; req_argc = CW'(argc); req_args = args;
        @(negedge clk);
        req_start = 1'b0;
        chk("R7 busy after start", call_busy, 1'b1);
        waitc = 0;
        while (log_cnt < base + n && waitc < 300) begin @(negedge clk); waitc++; end
        repeat (4) @(negedge clk);
        if (poke) begin
            req_start = 1'b1; req_target = tgt ^ 32'h1000; req_argc = 3'd2;
            @(negedge clk);
            req_start = 1'b0;
            repeat (8) @(negedge clk);
        end
        chk((argc == 0) ? "R5 only question write" : "R3 write count", log_cnt - base, n);
        if (poke) chk("R2 start while busy ignored", log_cnt - base, n);
        for (int k = 0; k < n - 1; k++) begin
            chk("R3 slot address", log_addr[8'(base + k)], slot_addr(tgt, k));
            chk("R3 slot data", log_data[8'(base + k)], args[k*DW +: DW]);
        end
        chk("R4 question address", log_addr[8'(base + n - 1)], tgt);
        chk("R4 question data", log_data[8'(base + n - 1)], RET);
        chk("R7 busy until answer", call_busy, 1'b1);
        if (zero_a) begin
            ret_write(SAW'(4), 32'h0);
            chk("R9 zero answer ignored", {call_busy, 32'(done_cnt)}, {1'b1, 32'(dc0)});
        end
        if (send_d) begin
            ret_write(SAW'(0), dval);
            exp_d = dval;
        end
        ret_write(SAW'(4), 32'h1 + ($urandom % 32'hFFFF));
        @(negedge clk);
        chk("R8 one-cycle done", done_cnt - dc0, 1);
        chk(send_d ? "R8 result value" : "R10 result kept", done_val, exp_d);
        chk("R7 busy cleared", call_busy, 1'b0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {call_busy, call_done, m_awvalid, m_wvalid, s_bvalid}, 5'b0);

        // Directed: zero args, clamp, poke while busy, zero answer
        do_call(32'h1000_0100, 0, '0, 32'hAAAA_0001, 1'b1, 1'b0, 1'b0);
        do_call(32'h1000_0200, 7, {32'h44, 32'h33, 32'h22, 32'h11}, 32'hBEEF, 1'b1, 1'b1, 1'b1);

        // Idle writes are acknowledged but discarded
        begin
            int dc;
            dc = done_cnt;
            ret_write(SAW'(0), 32'hDEAD_DEAD);
            ret_write(SAW'(4), 32'h1);
            repeat (3) @(negedge clk);
            chk("R10 no done while idle", {call_busy, 32'(done_cnt)}, {1'b0, 32'(dc)});
        end
        do_call(32'h1000_0300, 1, {96'h0, 32'h55}, 32'h0, 1'b0, 1'b0, 1'b0);

        // Random calls
        for (int i = 0; i < 40; i++) begin
            logic [NA*DW-1:0] a;
            for (int k = 0; k < NA; k++) a[k*DW +: DW] = $urandom;
            do_call($urandom & 32'hFFFF_FF00, int'($urandom % (NA + 1)), a, $urandom,
                    ($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 6) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule